// File: doc/BRIEF.md
# Reset and Calibration Sequencer

This block is the control sequencer that brings a clock-generator core out of reset and through an oscillator calibration. Two active-low pins, power-down and reset, each hold the core in reset for as long as they are low. Once both pins are high again, the sequencer fires a strobe that makes the register bank reload its default contents. It then waits for the supplies and the loop to settle, starts the calibration, waits for the calibration engine to report completion, and only then lets the clock outputs run.

A second path starts from software. A control bit that normally sits at 0 is written to 1 and back to 0. The falling edge restarts the settle-and-calibrate part of the sequence without the default reload, so the calibration runs on the frequency plan currently in the registers. A hardware reset always wins over this path, and it aborts the sequence at any point.

The settle step needs two things: the supply-good input must be high, and a settle counter of `SETTLE_CYC` cycles must have run to its end without supply-good dropping. While the sequence runs, the output-hold line is held high so that the core produces no runt or spurious clocks.

Top module: `rst_cal_sequencer`

## Requirements
- R1: While either `pwrdn_n` or `rstpin_n` is low, the block is in reset. `out_hold` is 1 and `busy`, `load_defaults` and `cal_start` are 0. The reset takes effect as soon as a pin falls, with no clock edge needed.
- R2: When both pins are high, the release passes through a two-flop synchronizer. `load_defaults` is then high for exactly one cycle, starting on the third rising clock edge after the pins went high.
- R3: After the default load, with `supply_ok` held high, `cal_start` goes high exactly `SETTLE_CYC`+2 cycles after the cycle in which `load_defaults` was high.
- R4: If `supply_ok` is low during the settle step, the settle count restarts. `cal_start` then goes high `SETTLE_CYC`+1 cycles after `supply_ok` is driven high again (the change is sampled on the next rising edge), and it never goes high while `supply_ok` is low.
- R5: `cal_start` is a one-cycle pulse. After it, `busy` and `out_hold` stay at 1 until `cal_done` is sampled high. On the next cycle both are 0 (normal operation).
- R6: `cal_done` has no effect unless a calibration has been started and has not yet finished.
- R7: A 1-to-0 change of `soft_rst` restarts the settle step. `busy` and `out_hold` are 1 from the second cycle after the falling value is sampled. `cal_start` follows `SETTLE_CYC`+3 cycles after the bit was cleared, and `load_defaults` stays 0 throughout.
- R8: Raising `soft_rst` to 1 and holding it there has no effect on `out_hold` or `busy`.
- R9: A pin reset during calibration aborts it at once (R1 state). After release, the full sequence runs again, including the default load.
- R10: A `soft_rst` falling edge that occurs while a pin holds the block in reset is discarded. After release, only the hardware path runs, with its default load at the R2 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| pwrdn_n | input | 1 | Power-down pin, active low, asynchronous |
| rstpin_n | input | 1 | Reset pin, active low, asynchronous |
| soft_rst | input | 1 | Software reset control bit, synchronous to clk |
| supply_ok | input | 1 | Supplies within range |
| cal_done | input | 1 | Calibration engine finished |
| load_defaults | output | 1 | One-cycle strobe: reload register defaults |
| cal_start | output | 1 | One-cycle strobe: begin calibration |
| out_hold | output | 1 | Clock outputs held in reset |
| busy | output | 1 | Reset sequence in progress |

## Verification
The bench measures the exact cycle of each strobe relative to its trigger. A synchronizer with one stage too many or too few, or a settle counter that is off by one, shows up as a shifted `load_defaults` or `cal_start`. It drops `supply_ok` in the middle of the settle count, which catches a counter that only pauses instead of restarting. It also pulses `cal_done` during the settle step, where a sequencer that obeys it would release the outputs early. The soft path is checked for a strobe that must never appear, since a design that reloads defaults there would destroy the current frequency plan. A pin pulled low during calibration, or during a pending soft reset, must end the sequence without a clock edge and must lead to the hardware path only.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_CALGO  = 3'd3,
        ST_CALRUN = 3'd4,
        ST_RUN    = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/rcs_pin_sync.sv
module rcs_pin_sync #(
    parameter int NPINS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [NPINS-1:0] pin_n,
    output logic             all_released
);
    logic [NPINS-1:0] rel;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], 1'b1};
        end

        always_ff @(posedge clk or negedge pin_n[p]) begin
            if (!pin_n[p]) sh_q <= '0;
            else           sh_q <= sh_d;
        end

        assign rel[p] = sh_q[STAGES-1];
    end

    assign all_released = &rel;
endmodule

// File: rtl/rcs_soft_edge.sv
module rcs_soft_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
        logic fall;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d.prev = bit_i;
        r_d.fall = r_q.prev & ~bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fall_o = r_q.fall;

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fall |=> !r_q.fall); // R7
endmodule

// File: rtl/rcs_settle_timer.sv
module rcs_settle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (run_i && cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == CW'(LIMIT));

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R3
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !done_o); // R4
endmodule

// File: rtl/rst_cal_sequencer.sv
module rst_cal_sequencer
    import rcs_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwrdn_n,
    input  logic rstpin_n,
    input  logic soft_rst,
    input  logic supply_ok,
    input  logic cal_done,
    output logic load_defaults,
    output logic cal_start,
    output logic out_hold,
    output logic busy
);
    logic       hw_rst_n;
    logic       pins_rel;
    logic       soft_fall;
    logic       tmr_run, tmr_clr, tmr_done;
    seq_regs_t  r_d, r_q;

    assign hw_rst_n = pwrdn_n & rstpin_n;

    rcs_pin_sync #(.NPINS(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .pin_n        ({pwrdn_n, rstpin_n}),
        .all_released (pins_rel)
    );

    rcs_soft_edge u_soft (
        .clk    (clk),
        .rst_n  (hw_rst_n),
        .bit_i  (soft_rst),
        .fall_o (soft_fall)
    );

    assign tmr_run = (r_q.state == ST_SETTLE) && supply_ok && !soft_fall;
    assign tmr_clr = !tmr_run;

    rcs_settle_timer #(.LIMIT(SETTLE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (hw_rst_n),
        .run_i  (tmr_run),
        .clr_i  (tmr_clr),
        .done_o (tmr_done)
    );

    always_comb begin
        r_d = r_q;
        if (!pins_rel) begin
            r_d.state = ST_HOLD;
        end else begin
            unique case (r_q.state)
                ST_HOLD:   r_d.state = ST_LOAD;
                ST_LOAD:   r_d.state = ST_SETTLE;
                ST_SETTLE: begin
                    if (soft_fall)                  r_d.state = ST_SETTLE;
                    else if (tmr_done && supply_ok) r_d.state = ST_CALGO;
                end
                ST_CALGO:  r_d.state = soft_fall ? ST_SETTLE : ST_CALRUN;
                ST_CALRUN: begin
                    if (soft_fall)     r_d.state = ST_SETTLE;
                    else if (cal_done) r_d.state = ST_RUN;
                end
                ST_RUN:    if (soft_fall) r_d.state = ST_SETTLE;
                default:   r_d.state = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) r_q.state <= ST_HOLD;
        else           r_q <= r_d;
    end

    assign load_defaults = (r_q.state == ST_LOAD);
    assign cal_start     = (r_q.state == ST_CALGO);
    assign out_hold      = (r_q.state != ST_RUN);
    assign busy          = (r_q.state != ST_RUN) && (r_q.state != ST_HOLD);

    AST_LOAD_AFTER_HOLD: assert property (@(posedge clk) disable iff (!hw_rst_n)
        load_defaults |-> $past(r_q.state == ST_HOLD)); // R2
    AST_CAL_GATED: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(cal_start) |-> $past(tmr_done && supply_ok)); // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        cal_start |=> !cal_start); // R5
    AST_SOFT_NO_LOAD: assert property (@(posedge clk) disable iff (!hw_rst_n)
        soft_fall |=> !load_defaults); // R7
    AST_RUN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $fell(out_hold) |-> $past(cal_done)); // R6
endmodule

// File: tb/rst_cal_sequencer_bench.sv
module rst_cal_sequencer_bench;
    localparam int K = 16;

    logic clk = 1'b0;
    logic pwrdn_n, rstpin_n, soft_rst, supply_ok, cal_done;
    logic load_defaults, cal_start, out_hold, busy;
    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rst_cal_sequencer #(.SETTLE_CYC(K)) u_rst_cal_sequencer (
        .clk(clk), .pwrdn_n(pwrdn_n), .rstpin_n(rstpin_n), .soft_rst(soft_rst),
        .supply_ok(supply_ok), .cal_done(cal_done), .load_defaults(load_defaults),
        .cal_start(cal_start), .out_hold(out_hold), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // negedges from now until cal_start is seen high; also reports any load strobe
    task automatic wait_cal(output int n, output int loads);
        n = 0; loads = 0;
        while (n < 500) begin
            @(negedge clk); n++;
            if (load_defaults) loads++;
            if (cal_start) break;
        end
    endtask

    task automatic wait_load(output int n);
        n = 0;
        while (n < 50) begin
            @(negedge clk); n++;
            if (load_defaults) break;
        end
    endtask

    task automatic finish_cal(input string req);
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        chk({req, " out_hold after done"}, out_hold, 0);
        chk({req, " busy after done"}, busy, 0);
    endtask

    task automatic t_reset_state;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R1 out_hold", out_hold, 1);
        chk("R1 busy", busy, 0);
        chk("R1 load", load_defaults, 0);
        chk("R1 cal_start", cal_start, 0);
    endtask

    task automatic t_power_up;
        int n, l;
        @(negedge clk); pwrdn_n = 1'b1; rstpin_n = 1'b1;
        wait_load(n);
        chk("R2 load delay", n, 3);
        wait_cal(n, l);
        chk("R2 load width", l, 0);
        chk("R3 cal delay", n, K + 2);
        @(negedge clk);
        chk("R5 start pulse width", cal_start, 0);
        chk("R5 hold during cal", out_hold, 1);
        chk("R5 busy during cal", busy, 1);
        finish_cal("R5");
    endtask

    task automatic t_soft;
        int n, l;
        @(negedge clk); soft_rst = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R8 hold unchanged", out_hold, 0);
        chk("R8 busy unchanged", busy, 0);
        soft_rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 busy after fall", busy, 1);
        chk("R7 hold after fall", out_hold, 1);
        wait_cal(n, l);
        chk("R7 cal delay", n + 2, K + 3);
        chk("R7 no default load", l, 0);
        finish_cal("R7");
    endtask

    task automatic t_supply_drop;
        int n, l;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        for (int i = 0; i < 6; i++) @(negedge clk);
        supply_ok = 1'b0;
        l = 0;
        for (int i = 0; i < 2 * K; i++) begin
            @(negedge clk);
            if (cal_start) l++;
        end
        chk("R4 no start while supply low", l, 0);
        supply_ok = 1'b1;
        wait_cal(n, l);
        chk("R4 restart delay", n, K + 1);
        finish_cal("R4");
    endtask

    task automatic t_done_ignored;
        int n, l;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        @(negedge clk);
        chk("R6 hold kept after early done", out_hold, 1);
        wait_cal(n, l);
        chk("R6 start still issued", cal_start, 1);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R6 busy waits for done", busy, 1);
        finish_cal("R6");
    endtask

    task automatic t_hw_abort;
        int n, l;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        wait_cal(n, l);
        @(negedge clk);
        #1 rstpin_n = 1'b0;
        #0.5;
        chk("R9 immediate hold", out_hold, 1);
        chk("R9 busy cleared", busy, 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        rstpin_n = 1'b1;
        wait_load(n);
        chk("R9 reload after abort", n, 3);
        wait_cal(n, l);
        chk("R9 recal delay", n, K + 2);
        finish_cal("R9");
    endtask

    task automatic t_hw_priority;
        int n, l;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); pwrdn_n = 1'b0;
        @(negedge clk); soft_rst = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R10 in reset", busy, 0);
        pwrdn_n = 1'b1;
        wait_load(n);
        chk("R10 hardware load", n, 3);
        wait_cal(n, l);
        chk("R10 cal delay", n, K + 2);
        finish_cal("R10");
    endtask

    initial begin
        pwrdn_n = 1'b0; rstpin_n = 1'b0; soft_rst = 1'b0;
        supply_ok = 1'b1; cal_done = 1'b0;
        t_reset_state();
        t_power_up();
        t_soft();
        t_supply_drop();
        t_done_ignored();
        t_hw_abort();
        t_hw_priority();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule